// File: doc/BRIEF.md
# Serial-Clocked Word Store Responder (Microwire-Style Read)

This block stands in for a small serial EEPROM of 64 sixteen-bit words that software drives entirely through one control register. Software toggles a serial clock bit, a select bit and a serial input bit by writing the register. It samples the serial output bit by reading the same register back. The block never sees a free-running serial clock. It compares the clock bit of each register write with the clock bit stored from the write before, and treats a change as a rising or falling serial edge.

After a select session opens, nine input bits are collected: a 3-bit command first, then a 6-bit word address. Only the read command (3'b110) is decoded. Once a read is active, every falling serial edge advances a bit pointer that runs through the store as one continuous bit stream. Words are sent most significant bit first and the stream rolls on into the following word. A preload port fills the store before use. The read value of the register is registered, and it settles two system clock cycles after the write strobe that changed it.

Top module: `uwire_eeprom_resp`

## Requirements
- R1: After reset the control read value is 9'h188: the present bit (bit 8), the grant bit (bit 7) and the serial output bit (bit 3) read 1, and every other bit reads 0.
- R2: The read value echoes the last written serial clock (bit 0), select (bit 1), serial input (bit 2), write-enable field (bits 5:4) and request (bit 6). Written values of bits 3, 7 and 8 are ignored, and bits 7 and 8 always read 1. A new value is visible no later than three system clocks after the write strobe.
- R3: A register write whose clock bit equals the stored clock bit changes no protocol state, even if it lowers the select bit or changes the serial input bit.
- R4: A rising serial edge with select high shifts the serial input bit into the LSB of the command shift register. On the ninth such edge, when no read is active, bits [8:6] (the first three bits sent) form the command and bits [5:0] the address. Command 3'b110 starts a read with the pointer at address*16-1, so the output bit then shows bit 0 of word address-1 (mod 64).
- R5: While reading, each falling serial edge advances the pointer by one. The output bit is bit 15-(p mod 16) of word (p/16) mod 64, so each word leaves MSB first and the stream continues into the next word.
- R6: The stream wraps from the last bit of word 63 to the MSB of word 0.
- R7: A rising serial edge with select low clears the read flag, the shift register, the input bit count and the pointer. The output bit returns to 1 and the next command is decoded from scratch.
- R8: A command other than 3'b110 leaves the output bit at 1. A command is decoded only once per session: further input bits cannot start a read until an R7 clear.
- R9: A preload write stores a word, and the streamed output bit reflects it, even when the preload lands in the same system cycle as a serial edge that moves the pointer into that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 9 | Control register write value |
| reg_rdata | output | 9 | Registered control register read value |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | ADDR_W (6) | Preload word address |
| pre_data | input | WORD_W (16) | Preload word value |

## Verification
Two pairs of functions can coincide in one system cycle. First, the ninth rising serial edge both shifts in the last address bit and decodes the command, so the decoded address must include the bit shifted on that same write. Every read in the vector table depends on this, and a wrong address shows up as a wrong stream against the bench's own word model. Second, a preload write and a falling serial edge are driven in the same cycle, with the edge moving the pointer onto the word being rewritten. The settled output bit is judged against the new word content.

// File: rtl/uwe_pkg.sv
`timescale 1ns/1ps
package uwe_pkg;
  localparam int CTRL_W = 9;

  // control register bit positions
  localparam int B_SCLK = 0;
  localparam int B_CSEL = 1;
  localparam int B_DIN  = 2;
  localparam int B_DOUT = 3;
  localparam int B_WEN0 = 4;
  localparam int B_WEN1 = 5;
  localparam int B_REQ  = 6;
  localparam int B_GNT  = 7;
  localparam int B_PRES = 8;

  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_READ = 3'b110;

  // bits kept from each write: clock, select, input, enable field, request
  localparam logic [CTRL_W-1:0] KEEP_MASK  = 9'h077;
  // bits that always read as one: grant and present
  localparam logic [CTRL_W-1:0] FIXED_ONES = 9'h180;
endpackage

// File: rtl/uwe_ctrl_latch.sv
`timescale 1ns/1ps
module uwe_ctrl_latch
  import uwe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] held,
  output logic              rise,
  output logic              fall,
  output logic              cs_now,
  output logic              din_now
);
  logic sclk_flip;

  always_ff @(posedge clk) begin
    if (rst)     held <= '0;
    else if (wr) held <= wdata & KEEP_MASK;
  end

  // a serial edge exists only when a write changes the stored clock bit
  always_comb begin
    sclk_flip = wr && (wdata[B_SCLK] != held[B_SCLK]);
    rise      = sclk_flip && wdata[B_SCLK];
    fall      = sclk_flip && !wdata[B_SCLK];
    cs_now    = wdata[B_CSEL];
    din_now   = wdata[B_DIN];
  end
endmodule

// File: rtl/uwe_proto.sv
`timescale 1ns/1ps
module uwe_proto
  import uwe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int BIT_W  = $clog2(WORD_W),
  parameter int PTR_W  = ADDR_W + BIT_W,
  parameter int CMD_W  = OP_W + ADDR_W,
  parameter int CNT_W  = $clog2(CMD_W + 1) + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             fall,
  input  logic             cs_now,
  input  logic             din_now,
  output logic             reading,
  output logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CMD_W-1:0] shift_q;
  logic [CMD_W-1:0] shift_nx;
  logic [PTR_W-1:0] start_ptr;
  logic             cmd_is_read;

  always_comb begin
    shift_nx    = {shift_q[CMD_W-2:0], din_now};
    start_ptr   = {shift_nx[ADDR_W-1:0], {BIT_W{1'b0}}} - PTR_W'(1);
    cmd_is_read = (shift_nx[CMD_W-1 -: OP_W] == OP_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      bit_cnt <= '0;
      reading <= 1'b0;
      ptr     <= '0;
    end else if (fall) begin
      ptr <= ptr + PTR_W'(1);
    end else if (rise) begin
      if (!cs_now) begin
        shift_q <= '0;
        bit_cnt <= '0;
        reading <= 1'b0;
        ptr     <= '0;
      end else begin
        shift_q <= shift_nx;
        // saturate so the decode point is passed only once per session
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == CNT_LAST && !reading) begin
          ptr     <= start_ptr;
          reading <= cmd_is_read;
        end
      end
    end
  end
endmodule

// File: rtl/uwe_store.sv
`timescale 1ns/1ps
module uwe_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
)(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [0:DEPTH-1];

  // one write port, one registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/uwire_eeprom_resp.sv
`timescale 1ns/1ps
module uwire_eeprom_resp
  import uwe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int PTR_W = ADDR_W + BIT_W;
  localparam int CMD_W = OP_W + ADDR_W;
  localparam int CNT_W = $clog2(CMD_W + 1) + 1;

  logic [CTRL_W-1:0] held;
  logic              rise, fall, cs_now, din_now;
  logic              reading;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sclk_q;
  logic [WORD_W-1:0] word_d1;

  logic [CTRL_W-1:0] held_d1;
  logic              reading_d1;
  logic [BIT_W-1:0]  lo_d1;
  logic [BIT_W-1:0]  bit_sel;
  logic              dout_bit;
  logic [CTRL_W-1:0] rd_nx;

  assign sclk_q = held[B_SCLK];

  uwe_ctrl_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .held    (held),
    .rise    (rise),
    .fall    (fall),
    .cs_now  (cs_now),
    .din_now (din_now)
  );

  uwe_proto #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .BIT_W  (BIT_W),
    .PTR_W  (PTR_W),
    .CMD_W  (CMD_W),
    .CNT_W  (CNT_W)
  ) u_proto (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .fall    (fall),
    .cs_now  (cs_now),
    .din_now (din_now),
    .reading (reading),
    .ptr     (ptr),
    .bit_cnt (bit_cnt)
  );

  uwe_store #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_store (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (ptr[PTR_W-1:BIT_W]),
    .rdata (word_d1)
  );

  // stage 1: align control state with the word read out of the store
  always_ff @(posedge clk) begin
    if (rst) begin
      held_d1    <= '0;
      reading_d1 <= 1'b0;
      lo_d1      <= '0;
    end else begin
      held_d1    <= held;
      reading_d1 <= reading;
      lo_d1      <= ptr[BIT_W-1:0];
    end
  end

  always_comb begin
    bit_sel         = BIT_W'(WORD_W - 1) - lo_d1;
    dout_bit        = reading_d1 ? word_d1[bit_sel] : 1'b1;
    rd_nx           = held_d1 | FIXED_ONES;
    rd_nx[B_DOUT]   = dout_bit;
  end

  // stage 2: registered read value
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata         <= FIXED_ONES;
      reg_rdata[B_DOUT] <= 1'b1;
    end else begin
      reg_rdata <= rd_nx;
    end
  end
endmodule

// File: rtl/uwe_checks.sv
`timescale 1ns/1ps
module uwe_checks
  import uwe_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int CNT_W = 5,
  parameter int CMD_W = 9
)(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [CTRL_W-1:0] reg_wdata,
  input logic [CTRL_W-1:0] reg_rdata,
  input logic              sclk_q,
  input logic              reading,
  input logic [PTR_W-1:0]  ptr,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R1 / R2: present and grant always read as one
  a_r2_fixed_ones: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[B_PRES] && reg_rdata[B_GNT]);

  // R3: no clock change, no protocol change
  a_r3_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (reg_wdata[B_SCLK] != sclk_q))
    |=> ($stable(ptr) && $stable(reading) && $stable(bit_cnt)));

  // R4: a read starts only on the ninth input bit
  a_r4_read_start: assert property (@(posedge clk) disable iff (rst)
    $rose(reading) |-> (bit_cnt == CNT_W'(CMD_W)));

  // R5: falling serial edge steps the pointer by one
  a_r5_fall_step: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sclk_q && !reg_wdata[B_SCLK])
    |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1))));

  // R7: rising edge with select low clears protocol state
  a_r7_cs_low_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !sclk_q && reg_wdata[B_SCLK] && !reg_wdata[B_CSEL])
    |=> (!reading && bit_cnt == '0 && ptr == '0));
endmodule

bind uwire_eeprom_resp uwe_checks #(
  .PTR_W (PTR_W),
  .CNT_W (CNT_W),
  .CMD_W (CMD_W)
) u_checks (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .sclk_q    (sclk_q),
  .reading   (reading),
  .ptr       (ptr),
  .bit_cnt   (bit_cnt)
);

// File: tb/test_uwire_eeprom_resp.sv
`timescale 1ns/1ps
module test_uwire_eeprom_resp;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              reg_wr;
  logic [8:0]        reg_wdata;
  logic [8:0]        reg_rdata;
  logic              pre_we;
  logic [ADDR_W-1:0] pre_addr;
  logic [WORD_W-1:0] pre_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [15:0] model [DEPTH];
  logic [8:0]  cur;

  always #2.5 clk = ~clk;

  uwire_eeprom_resp #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_uwire_eeprom_resp (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pre_we    (pre_we),
    .pre_addr  (pre_addr),
    .pre_data  (pre_data)
  );

  // {op[13:11], addr[10:5], bits to stream[4:0]}
  localparam logic [13:0] VEC [0:7] = '{
    {3'b110, 6'd5,  5'd20},
    {3'b110, 6'd63, 5'd24},
    {3'b110, 6'd0,  5'd18},
    {3'b110, 6'd31, 5'd16},
    {3'b101, 6'd7,  5'd6},
    {3'b111, 6'd9,  5'd4},
    {3'b010, 6'd3,  5'd4},
    {3'b110, 6'd40, 5'd17}
  };

  function automatic logic [15:0] word_init(input int i);
    return 16'((i * 40503) ^ 16'h3C96 ^ (i << 9));
  endfunction

  function automatic logic model_bit(input int p);
    int q;
    logic [15:0] w;
    q = p & 1023;
    w = model[q >> 4];
    return w[15 - (q & 15)];
  endfunction

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic put(input logic [8:0] v);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = v;
    cur       = v;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic drive(input logic sclk, input logic cs, input logic din);
    logic [8:0] v;
    v = cur;
    v[0] = sclk;
    v[1] = cs;
    v[2] = din;
    put(v);
  endtask

  task automatic expect_bit(input string tag, input logic e);
    settle();
    check(tag, {8'h0, reg_rdata[3]}, {8'h0, e});
  endtask

  task automatic fresh();
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [5:0] addr);
    logic [8:0] cmd;
    cmd = {op, addr};
    for (int i = 8; i >= 0; i--) begin
      drive(1'b0, 1'b1, cmd[i]);
      drive(1'b1, 1'b1, cmd[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_wdata = '0; cur = '0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    check("R1 reset value", reg_rdata, 9'h188);

    // R9: preload the whole store
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 6'(i); pre_data = word_init(i);
      model[i] = word_init(i);
    end
    @(negedge clk);
    pre_we = 1'b0;

    // R2: echo of kept bits, masked bits ignored
    put(9'h074);
    settle();
    check("R2 echo kept bits", reg_rdata, 9'h1FC);
    put(9'h008);
    settle();
    check("R2 read-only bits ignored", reg_rdata, 9'h188);

    // vector table: R4 decode, R5 stream, R6 wrap, R8 other commands
    for (int v = 0; v < 8; v++) begin
      logic [2:0] op;
      logic [5:0] ad;
      int nb, p;
      bit rd;
      string tag;
      op = VEC[v][13:11];
      ad = VEC[v][10:5];
      nb = int'(VEC[v][4:0]);
      rd = (op == 3'b110);
      tag = !rd ? "R8 non-read command" : (ad == 6'd63) ? "R6 wrap stream" : "R5 stream";
      fresh();
      send_cmd(op, ad);
      p = int'(ad) * 16 - 1;
      expect_bit("R4 first bit after decode", rd ? model_bit(p) : 1'b1);
      for (int k = 0; k < nb; k++) begin
        drive(1'b0, 1'b1, 1'b0);
        p++;
        expect_bit(tag, rd ? model_bit(p) : 1'b1);
        drive(1'b1, 1'b1, 1'b0);
      end
    end

    // R3: writes without a clock change leave the stream untouched
    fresh();
    send_cmd(3'b110, 6'd10);
    drive(1'b0, 1'b1, 1'b0);
    expect_bit("R3 stream start", model_bit(160));
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    expect_bit("R3 select low without edge", model_bit(160));
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    expect_bit("R3 stream continues", model_bit(161));

    // R7: rising edge with select low ends the read
    drive(1'b1, 1'b0, 1'b0);
    expect_bit("R7 clear gives idle output", 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b1, 1'b1);
      drive(1'b1, 1'b1, 1'b1);
    end
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    send_cmd(3'b110, 6'd12);
    expect_bit("R7 fresh decode after partial", model_bit(12 * 16 - 1));
    drive(1'b0, 1'b1, 1'b0);
    expect_bit("R7 fresh stream", model_bit(192));

    // R8: decode happens once per session
    fresh();
    send_cmd(3'b011, 6'd2);
    expect_bit("R8 other command idle", 1'b1);
    send_cmd(3'b110, 6'd4);
    expect_bit("R8 no second decode", 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    expect_bit("R8 no second decode stream", 1'b1);

    // R9: preload coinciding with a falling edge into the same word
    fresh();
    send_cmd(3'b110, 6'd20);
    drive(1'b0, 1'b1, 1'b0);
    expect_bit("R9 before rewrite", model_bit(320));
    drive(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    model[20] = ~model[20];
    reg_wr = 1'b1; reg_wdata = cur; reg_wdata[0] = 1'b0; cur = reg_wdata;
    pre_we = 1'b1; pre_addr = 6'd20; pre_data = model[20];
    @(negedge clk);
    reg_wr = 1'b0; pre_we = 1'b0;
    expect_bit("R9 same-cycle preload", model_bit(321));
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    expect_bit("R9 new word continues", model_bit(322));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule